// File: doc/BRIEF.md
# Translation Buffer Array with Broadcast Invalidation

This block holds one small fully associative translation buffer per core and a central invalidation broadcaster between them. Each buffer maps a virtual page number and an address-space identifier to a physical page number and an attribute field. Only the core's own page-walk port can fill it. Each buffer answers lookups one cycle after they are presented.

When a core changes a page-table entry, it raises an invalidate request toward the broadcaster. The request either names one page in one address space or asks for a full flush. The broadcaster serves one request at a time and forwards the message to the buffers of all other cores. It waits until every receiving buffer has acknowledged, then gives the issuing core a one-cycle completion pulse. The coherency path can only remove entries. It never creates or changes one.

Top module: `tlb_shootdown_top`

## Requirements
- R1: A lookup presented with `lk_valid` is answered in the next cycle with `lk_rsp`=1. `lk_hit`=1 and the stored physical page and attribute are returned only if a valid entry matches both the virtual page and the address-space identifier. On a miss, `lk_ppn` and `lk_attr` are 0.
- R2: After reset every entry of every core is invalid, the broadcaster is idle, and `lk_rsp`, `lk_hit` and `inv_done` are 0.
- R3: A fill writes the slot under a per-core replacement pointer. The pointer starts at slot 0 after reset and advances by one on each accepted fill, wrapping after the last slot. With ENTRIES slots, fill number ENTRIES+1 overwrites the first page filled.
- R4: A page invalidate removes, in every non-issuing core, each entry equal in both virtual page and address-space identifier. Entries that differ in either field stay valid. An invalidate never makes an absent page hit.
- R5: An invalidate with `inv_all`=1 clears every valid entry in every non-issuing core.
- R6: The issuing core's own buffer is never modified by its own invalidate request.
- R7: A request accepted by an idle broadcaster at clock edge k yields `inv_done` for the issuer high in exactly the cycle after edge k+2, for one cycle only. This follows the collection of an acknowledgement from every receiving core. The requester holds `inv_req` until it sees `inv_done` and then drops it.
- R8: When several cores request in the same cycle, the lowest-numbered core is served first. A pending request is accepted only once the broadcaster is idle again.
- R9: A lookup sampled in the same cycle as a matching invalidate reaches the buffer reports a miss.
- R10: A fill that arrives while an accepted invalidate is still in flight (from acceptance until completion) is discarded if its page and identifier match the message, or if the message is a flush. Fills that do not match are written normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | N_CORES | Lookup request per core |
| lk_vpn | input | N_CORES*VPN_W | Lookup virtual page, per core slice |
| lk_asid | input | N_CORES*ASID_W | Lookup address-space identifier, per core slice |
| lk_rsp | output | N_CORES | Lookup answered (one cycle after request) |
| lk_hit | output | N_CORES | Lookup hit |
| lk_ppn | output | N_CORES*PPN_W | Physical page on hit, else 0 |
| lk_attr | output | N_CORES*ATTR_W | Attribute on hit, else 0 |
| fill_valid | input | N_CORES | Local fill from the page walker |
| fill_vpn | input | N_CORES*VPN_W | Fill virtual page |
| fill_asid | input | N_CORES*ASID_W | Fill address-space identifier |
| fill_ppn | input | N_CORES*PPN_W | Fill physical page |
| fill_attr | input | N_CORES*ATTR_W | Fill attribute |
| inv_req | input | N_CORES | Invalidate request, held until completion |
| inv_all | input | N_CORES | Request is a full flush |
| inv_vpn | input | N_CORES*VPN_W | Page to invalidate |
| inv_asid | input | N_CORES*ASID_W | Identifier to invalidate |
| inv_done | output | N_CORES | One-cycle completion pulse to the issuer |

## Verification
The hardest situations to reach are the narrow windows inside one broadcast. One is a lookup sampled exactly while the invalidate message sits at a receiving buffer. Another is a fill landing between acceptance and completion. A third is two requests colliding at an idle broadcaster. The bench drives these at negative edges counted from the request edge. The lookup goes in the cycle after acceptance, and a matching fill and a non-matching fill are issued in the same cycle. It then reads the outcome through ordinary lookups after completion.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    BC_IDLE = 2'd0,
    BC_SEND = 2'd1,
    BC_WAIT = 2'd2
  } bc_state_e;
endpackage

// File: rtl/inv_broadcaster.sv
module inv_broadcaster
  import tlb_pkg::*;
#(
  parameter int N_CORES = 3,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_CORES-1:0]        req,
  input  logic [N_CORES-1:0]        req_all,
  input  logic [N_CORES*VPN_W-1:0]  req_vpn,
  input  logic [N_CORES*ASID_W-1:0] req_asid,
  input  logic [N_CORES-1:0]        ack,
  output logic [N_CORES-1:0]        bcast,
  output logic                      busy,
  output logic                      msg_all,
  output logic [VPN_W-1:0]          msg_vpn,
  output logic [ASID_W-1:0]         msg_asid,
  output logic [N_CORES-1:0]        done
);
  localparam int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  bc_state_e          st_q;
  logic [N_CORES-1:0] target_q, seen_q, issuer_q;
  logic [IDX_W-1:0]   sel;
  logic               sel_v;

  // Fixed priority: lowest core index wins.
  always_comb begin
    sel   = '0;
    sel_v = 1'b0;
    for (int i = N_CORES - 1; i >= 0; i--) begin
      if (req[i]) begin
        sel   = IDX_W'(i);
        sel_v = 1'b1;
      end
    end
  end

  assign busy = (st_q != BC_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= BC_IDLE;
      target_q <= '0;
      seen_q   <= '0;
      issuer_q <= '0;
      bcast    <= '0;
      done     <= '0;
      msg_all  <= 1'b0;
      msg_vpn  <= '0;
      msg_asid <= '0;
    end else begin
      done <= '0;
      case (st_q)
        BC_IDLE: begin
          if (sel_v) begin
            issuer_q <= N_CORES'(1) << sel;
            target_q <= ~(N_CORES'(1) << sel);
            bcast    <= ~(N_CORES'(1) << sel);
            msg_all  <= req_all[sel];
            msg_vpn  <= req_vpn[int'(sel)*VPN_W +: VPN_W];
            msg_asid <= req_asid[int'(sel)*ASID_W +: ASID_W];
            seen_q   <= '0;
            st_q     <= BC_SEND;
          end
        end
        BC_SEND: begin
          bcast <= '0;
          st_q  <= BC_WAIT;
        end
        BC_WAIT: begin
          if ((seen_q | ack) == target_q) begin
            done <= issuer_q;
            st_q <= BC_IDLE;
          end else begin
            seen_q <= seen_q | ack;
          end
        end
        default: st_q <= BC_IDLE;
      endcase
    end
  end

  p_done_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done));
  p_done_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (done != '0) |-> $past(ack != '0));
  p_bcast_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (bcast != '0) |=> (bcast == '0));
endmodule

// File: rtl/tlb_core.sv
module tlb_core #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int ATTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_rsp,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [ATTR_W-1:0] lk_attr,
  input  logic              fill_v,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic              inv_v,
  input  logic              pend_v,
  input  logic              msg_all,
  input  logic [VPN_W-1:0]  msg_vpn,
  input  logic [ASID_W-1:0] msg_asid,
  output logic              inv_ack
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q   [ENTRIES];
  logic [ASID_W-1:0]  asid_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_mem [ENTRIES];
  logic [ATTR_W-1:0]  attr_mem[ENTRIES];
  logic [PTR_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] look_m, kill_m;
  logic               fill_block, fill_we;
  logic [PTR_W-1:0]   hit_idx;
  logic               any_hit;

  // A fill colliding with an in-flight invalidate of the same page is dropped.
  assign fill_block = pend_v && (msg_all || (msg_vpn == fill_vpn && msg_asid == fill_asid));
  assign fill_we    = fill_v && !fill_block;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
    assign kill_m[gi] = inv_v && (msg_all ||
                        (vpn_q[gi] == msg_vpn && asid_q[gi] == msg_asid));
    assign look_m[gi] = vld_q[gi] && !kill_m[gi] &&
                        vpn_q[gi] == lk_vpn && asid_q[gi] == lk_asid;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[gi] <= 1'b0;
      end else if (fill_we && ptr_q == PTR_W'(gi)) begin
        vld_q[gi] <= 1'b1;
      end else if (kill_m[gi]) begin
        vld_q[gi] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vpn_q[gi]  <= '0;
        asid_q[gi] <= '0;
      end else if (fill_we && ptr_q == PTR_W'(gi)) begin
        vpn_q[gi]  <= fill_vpn;
        asid_q[gi] <= fill_asid;
      end
    end
  end

  // Payload storage: write-only port plus one read port, no reset.
  always_ff @(posedge clk) begin
    if (fill_we) begin
      ppn_mem[ptr_q]  <= fill_ppn;
      attr_mem[ptr_q] <= fill_attr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (fill_we) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  // Lowest matching slot wins.
  always_comb begin
    hit_idx = '0;
    any_hit = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (look_m[i]) begin
        hit_idx = PTR_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_rsp  <= 1'b0;
      lk_hit  <= 1'b0;
      lk_ppn  <= '0;
      lk_attr <= '0;
      inv_ack <= 1'b0;
    end else begin
      lk_rsp  <= lk_valid;
      lk_hit  <= lk_valid && any_hit;
      lk_ppn  <= (lk_valid && any_hit) ? ppn_mem[hit_idx]  : '0;
      lk_attr <= (lk_valid && any_hit) ? attr_mem[hit_idx] : '0;
      inv_ack <= inv_v;
    end
  end

  p_rsp_next_r1: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_rsp);
  p_miss_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (lk_rsp && !lk_hit) |-> (lk_ppn == '0 && lk_attr == '0));
  p_no_stale_hit_r9: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && inv_v && msg_all) |=> (lk_rsp && !lk_hit));
  p_ack_follows_r7: assert property (@(posedge clk) disable iff (rst)
    inv_v |=> inv_ack);
  p_fill_dropped_r10: assert property (@(posedge clk) disable iff (rst)
    (fill_v && fill_block && !inv_v) |=> (vld_q == $past(vld_q)));
endmodule

// File: rtl/tlb_shootdown_top.sv
module tlb_shootdown_top #(
  parameter int N_CORES = 3,
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int ATTR_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_CORES-1:0]        lk_valid,
  input  logic [N_CORES*VPN_W-1:0]  lk_vpn,
  input  logic [N_CORES*ASID_W-1:0] lk_asid,
  output logic [N_CORES-1:0]        lk_rsp,
  output logic [N_CORES-1:0]        lk_hit,
  output logic [N_CORES*PPN_W-1:0]  lk_ppn,
  output logic [N_CORES*ATTR_W-1:0] lk_attr,
  input  logic [N_CORES-1:0]        fill_valid,
  input  logic [N_CORES*VPN_W-1:0]  fill_vpn,
  input  logic [N_CORES*ASID_W-1:0] fill_asid,
  input  logic [N_CORES*PPN_W-1:0]  fill_ppn,
  input  logic [N_CORES*ATTR_W-1:0] fill_attr,
  input  logic [N_CORES-1:0]        inv_req,
  input  logic [N_CORES-1:0]        inv_all,
  input  logic [N_CORES*VPN_W-1:0]  inv_vpn,
  input  logic [N_CORES*ASID_W-1:0] inv_asid,
  output logic [N_CORES-1:0]        inv_done
);
  logic [N_CORES-1:0] bcast, ack;
  logic               busy, msg_all;
  logic [VPN_W-1:0]   msg_vpn;
  logic [ASID_W-1:0]  msg_asid;

  inv_broadcaster #(
    .N_CORES(N_CORES), .VPN_W(VPN_W), .ASID_W(ASID_W)
  ) u_bc (
    .clk(clk), .rst(rst),
    .req(inv_req), .req_all(inv_all), .req_vpn(inv_vpn), .req_asid(inv_asid),
    .ack(ack), .bcast(bcast), .busy(busy),
    .msg_all(msg_all), .msg_vpn(msg_vpn), .msg_asid(msg_asid),
    .done(inv_done)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    tlb_core #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
      .ASID_W(ASID_W), .ATTR_W(ATTR_W)
    ) u_tlb (
      .clk(clk), .rst(rst),
      .lk_valid(lk_valid[c]),
      .lk_vpn(lk_vpn[c*VPN_W +: VPN_W]),
      .lk_asid(lk_asid[c*ASID_W +: ASID_W]),
      .lk_rsp(lk_rsp[c]),
      .lk_hit(lk_hit[c]),
      .lk_ppn(lk_ppn[c*PPN_W +: PPN_W]),
      .lk_attr(lk_attr[c*ATTR_W +: ATTR_W]),
      .fill_v(fill_valid[c]),
      .fill_vpn(fill_vpn[c*VPN_W +: VPN_W]),
      .fill_asid(fill_asid[c*ASID_W +: ASID_W]),
      .fill_ppn(fill_ppn[c*PPN_W +: PPN_W]),
      .fill_attr(fill_attr[c*ATTR_W +: ATTR_W]),
      .inv_v(bcast[c]),
      .pend_v(busy),
      .msg_all(msg_all),
      .msg_vpn(msg_vpn),
      .msg_asid(msg_asid),
      .inv_ack(ack[c])
    );
  end
endmodule

// File: tb/tb_tlb_shootdown_top.sv
`timescale 1ns/1ps
module tb_tlb_shootdown_top;
  localparam int N  = 3;
  localparam int E  = 8;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int AW = 8;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [N-1:0]    lk_valid = '0, lk_rsp, lk_hit;
  logic [N*VW-1:0] lk_vpn = '0;
  logic [N*AW-1:0] lk_asid = '0;
  logic [N*PW-1:0] lk_ppn;
  logic [N*TW-1:0] lk_attr;
  logic [N-1:0]    fill_valid = '0;
  logic [N*VW-1:0] fill_vpn = '0;
  logic [N*AW-1:0] fill_asid = '0;
  logic [N*PW-1:0] fill_ppn = '0;
  logic [N*TW-1:0] fill_attr = '0;
  logic [N-1:0]    inv_req = '0, inv_all = '0, inv_done;
  logic [N*VW-1:0] inv_vpn = '0;
  logic [N*AW-1:0] inv_asid = '0;

  tlb_shootdown_top #(.N_CORES(N), .ENTRIES(E), .VPN_W(VW), .PPN_W(PW),
                      .ASID_W(AW), .ATTR_W(TW)) dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_rsp(lk_rsp), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_attr(lk_attr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_ppn(fill_ppn), .fill_attr(fill_attr),
    .inv_req(inv_req), .inv_all(inv_all), .inv_vpn(inv_vpn), .inv_asid(inv_asid),
    .inv_done(inv_done)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  // {core, vpn, asid, expected hit, expected ppn, expected attr}
  localparam logic [54:0] VEC [8] = '{
    {2'd0, 20'h00010, 8'd1, 1'b1, 20'hA0010, 4'd3},
    {2'd0, 20'h00011, 8'd1, 1'b1, 20'hA0011, 4'd5},
    {2'd0, 20'h00010, 8'd2, 1'b1, 20'hB0010, 4'd6},
    {2'd0, 20'h12345, 8'd7, 1'b1, 20'hC1234, 4'd9},
    {2'd0, 20'h00011, 8'd2, 1'b0, 20'h00000, 4'd0},
    {2'd0, 20'h12345, 8'd1, 1'b0, 20'h00000, 4'd0},
    {2'd0, 20'h00099, 8'd1, 1'b0, 20'h00000, 4'd0},
    {2'd1, 20'h00010, 8'd1, 1'b0, 20'h00000, 4'd0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_fill(input int c, input logic [VW-1:0] v, input logic [AW-1:0] a,
                         input logic [PW-1:0] p, input logic [TW-1:0] t);
    @(negedge clk);
    fill_valid[c] = 1'b1;
    fill_vpn[c*VW +: VW] = v;
    fill_asid[c*AW +: AW] = a;
    fill_ppn[c*PW +: PW] = p;
    fill_attr[c*TW +: TW] = t;
    @(negedge clk);
    fill_valid[c] = 1'b0;
  endtask

  task automatic do_look(input int c, input logic [VW-1:0] v, input logic [AW-1:0] a,
                         output logic h, output logic [PW-1:0] p, output logic [TW-1:0] t);
    @(negedge clk);
    lk_valid[c] = 1'b1;
    lk_vpn[c*VW +: VW] = v;
    lk_asid[c*AW +: AW] = a;
    @(negedge clk);
    h = lk_hit[c];
    p = lk_ppn[c*PW +: PW];
    t = lk_attr[c*TW +: TW];
    lk_valid[c] = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input int c, input logic [VW-1:0] v,
                            input logic [AW-1:0] a, input logic eh);
    logic h;
    logic [PW-1:0] p;
    logic [TW-1:0] t;
    do_look(c, v, a, h, p, t);
    check(tag, 64'(h), 64'(eh));
  endtask

  task automatic set_inv(input int c, input logic all, input logic [VW-1:0] v,
                         input logic [AW-1:0] a);
    inv_req[c] = 1'b1;
    inv_all[c] = all;
    inv_vpn[c*VW +: VW] = v;
    inv_asid[c*AW +: AW] = a;
  endtask

  // Waits for completion, checks latency (3 negedges after request set) and pulse width.
  task automatic finish_inv(input int c, input int already, input string tag);
    int lat = already;
    while (!inv_done[c] && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(tag, 64'(lat), 64'd3);
    inv_req[c] = 1'b0;
    @(negedge clk);
    check({tag, " pulse"}, 64'(inv_done[c]), 64'd0);
  endtask

  task automatic do_inv(input int c, input logic all, input logic [VW-1:0] v,
                        input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    set_inv(c, all, v, a);
    finish_inv(c, 0, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic h;
    logic [PW-1:0] p;
    logic [TW-1:0] t;
    logic [54:0] vrow;
    int dn1, dn2;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset state
    check("R2 lk_rsp", 64'(lk_rsp), 64'd0);
    check("R2 lk_hit", 64'(lk_hit), 64'd0);
    check("R2 inv_done", 64'(inv_done), 64'd0);
    do_look(0, 20'h0, 8'h0, h, p, t);
    check("R2 empty lookup miss", 64'(h), 64'd0);
    check("R1 rsp raised", 64'(lk_rsp[0]), 64'd1);

    // R1: table of lookups
    do_fill(0, 20'h00010, 8'd1, 20'hA0010, 4'd3);
    do_fill(0, 20'h00011, 8'd1, 20'hA0011, 4'd5);
    do_fill(0, 20'h00010, 8'd2, 20'hB0010, 4'd6);
    do_fill(0, 20'h12345, 8'd7, 20'hC1234, 4'd9);
    for (int k = 0; k < 8; k++) begin
      vrow = VEC[k];
      do_look(int'(vrow[54:53]), vrow[52:33], vrow[32:25], h, p, t);
      check($sformatf("R1 vec%0d hit", k), 64'(h), 64'(vrow[24]));
      check($sformatf("R1 vec%0d ppn", k), 64'(p), 64'(vrow[23:4]));
      check($sformatf("R1 vec%0d attr", k), 64'(t), 64'(vrow[3:0]));
    end

    // R3: round-robin replacement on core 2
    for (int k = 0; k <= E; k++) do_fill(2, 20'h00200 + 20'(k), 8'd3, 20'hD0000 + 20'(k), 4'd1);
    expect_hit("R3 oldest evicted", 2, 20'h00200, 8'd3, 1'b0);
    expect_hit("R3 second kept", 2, 20'h00201, 8'd3, 1'b1);
    expect_hit("R3 newest present", 2, 20'h00208, 8'd3, 1'b1);

    // R4: page invalidate from core 2 matches vpn and asid
    do_fill(1, 20'h00010, 8'd1, 20'hE0010, 4'd2);
    do_fill(1, 20'h00010, 8'd2, 20'hE0011, 4'd2);
    do_fill(1, 20'h00011, 8'd1, 20'hE0012, 4'd2);
    do_inv(2, 1'b0, 20'h00010, 8'd1, "R7 latency page");
    expect_hit("R4 core1 match cleared", 1, 20'h00010, 8'd1, 1'b0);
    expect_hit("R4 core1 other asid kept", 1, 20'h00010, 8'd2, 1'b1);
    expect_hit("R4 core1 other vpn kept", 1, 20'h00011, 8'd1, 1'b1);
    expect_hit("R4 core0 match cleared", 0, 20'h00010, 8'd1, 1'b0);
    expect_hit("R4 core2 absent stays miss", 2, 20'h00010, 8'd1, 1'b0);
    expect_hit("R6 core2 own kept", 2, 20'h00205, 8'd3, 1'b1);

    // R6: issuer untouched
    do_inv(0, 1'b0, 20'h00011, 8'd1, "R7 latency issuer");
    expect_hit("R6 core0 own entry kept", 0, 20'h00011, 8'd1, 1'b1);
    expect_hit("R4 core1 cleared by core0", 1, 20'h00011, 8'd1, 1'b0);

    // R9: lookup in the cycle the message reaches core 1
    do_fill(1, 20'h00050, 8'd4, 20'hF0050, 4'd7);
    expect_hit("R1 pre-inv hit", 1, 20'h00050, 8'd4, 1'b1);
    @(negedge clk);
    set_inv(0, 1'b0, 20'h00050, 8'd4);
    @(negedge clk);
    lk_valid[1] = 1'b1;
    lk_vpn[1*VW +: VW] = 20'h00050;
    lk_asid[1*AW +: AW] = 8'd4;
    @(negedge clk);
    lk_valid[1] = 1'b0;
    check("R9 same-cycle miss", 64'(lk_hit[1]), 64'd0);
    check("R9 rsp", 64'(lk_rsp[1]), 64'd1);
    finish_inv(0, 2, "R7 latency R9");

    // R10: fills during an in-flight invalidate
    @(negedge clk);
    set_inv(0, 1'b0, 20'h00060, 8'd5);
    @(negedge clk);
    fill_valid[2] = 1'b1;
    fill_vpn[2*VW +: VW] = 20'h00060;
    fill_asid[2*AW +: AW] = 8'd5;
    fill_ppn[2*PW +: PW] = 20'h60060;
    fill_valid[1] = 1'b1;
    fill_vpn[1*VW +: VW] = 20'h00061;
    fill_asid[1*AW +: AW] = 8'd5;
    fill_ppn[1*PW +: PW] = 20'h60061;
    @(negedge clk);
    fill_valid = '0;
    finish_inv(0, 2, "R7 latency R10");
    expect_hit("R10 matching fill dropped", 2, 20'h00060, 8'd5, 1'b0);
    do_look(1, 20'h00061, 8'd5, h, p, t);
    check("R10 other fill kept", 64'(h), 64'd1);
    check("R10 other fill ppn", 64'(p), 64'h60061);

    // R8: simultaneous requests, lowest index first
    do_fill(0, 20'h00070, 8'd1, 20'h70070, 4'd1);
    do_fill(0, 20'h00071, 8'd1, 20'h70071, 4'd1);
    @(negedge clk);
    set_inv(1, 1'b0, 20'h00070, 8'd1);
    set_inv(2, 1'b0, 20'h00071, 8'd1);
    dn1 = 0;
    dn2 = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (inv_done[1] && dn1 == 0) begin
        dn1 = k;
        inv_req[1] = 1'b0;
      end
      if (inv_done[2] && dn2 == 0) begin
        dn2 = k;
        inv_req[2] = 1'b0;
      end
    end
    check("R8 core1 first", 64'(dn1), 64'd3);
    check("R8 core2 after", 64'(dn2), 64'd6);
    expect_hit("R8 page of core1 cleared", 0, 20'h00070, 8'd1, 1'b0);
    expect_hit("R8 page of core2 cleared", 0, 20'h00071, 8'd1, 1'b0);

    // R5: flush from core 1
    do_inv(1, 1'b1, 20'h0, 8'd0, "R7 latency flush");
    expect_hit("R5 core0 cleared a", 0, 20'h00010, 8'd2, 1'b0);
    expect_hit("R5 core0 cleared b", 0, 20'h12345, 8'd7, 1'b0);
    expect_hit("R5 core2 cleared", 2, 20'h00205, 8'd3, 1'b0);
    expect_hit("R6 core1 kept on flush", 1, 20'h00010, 8'd2, 1'b1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule